// File: doc/BRIEF.md
# Second-Order Tributary Demultiplexer with Stuff Decoding

This block sits behind a second-order frame aligner. The aligner delivers the serial line one bit per `in_valid` strobe. With each bit it gives the bit's coordinates in the frame:

- the subframe number, 0 to 3;
- the block number inside that subframe, 0 to 5;
- the bit position inside that block, 0 to 48, where position 0 is the overhead bit.

The 48 payload bits of each block carry four first-order tributaries, bit-interleaved in a fixed rotation. The second and fourth tributaries travel inverted on the line.

Each subframe carries three stuff-control bits in the overhead slots of blocks 1, 3 and 4. Together they say whether one payload position in the last block (block 5) holds real data or a dummy bit. Which payload position that is depends on the subframe, so each tributary gets one stuffing opportunity per superframe.

A control pattern that does not vote for stuffing instead asks for a loopback of that subframe's tributary. The block decodes this request and filters it over consecutive superframes.

Outputs are registered. Each tributary has one data bit and one valid strobe, both appearing one clock after the line bit. Each tributary also has a loopback request level. Smoothing the gapped tributary clocks is left to downstream logic.

Top module: `t2dm_demux`

## Requirements
- R1: After reset, and on every reset, `trib_vld`, `trib_bit` and `loop_req` are all zero. The loopback history is also cleared, so a single loopback pattern seen after reset does not raise `loop_req`.
- R2: A payload bit at position p (1..48) belongs to tributary lane (p-1) mod 4. One clock after it is accepted, the design raises `trib_vld[lane]` alone and places the bit on `trib_bit[lane]`. `trib_vld` is never more than one-hot.
- R3: Lanes 1 and 3 (the second and fourth tributaries) are output as the inverse of the line bit. Lanes 0 and 2 are output unchanged.
- R4: No strobe is produced in the clock after any of the following:
  - an overhead bit (position 0);
  - a cycle with `in_valid` low;
  - a cycle with `sync_ok` low.
- R5: The control bits are the overhead bits of blocks 1, 3 and 4, named C1, C2 and C3 in that order. The subframe is stuffed exactly when {C1,C2,C3} is 111, 101 or 011. That is a majority of ones, leaving out the loopback pattern.
- R6: The stuff position is payload position p = subframe+1 in block 5 of that subframe. When the subframe is stuffed, that bit produces no strobe. Otherwise the bit is delivered as ordinary data of its lane.
- R7: {C1,C2,C3} equal to 110 or 001 (C1 equal to C2, C3 different) is the loopback pattern for lane = subframe. The pattern is sampled only at a C3 bit received while `sync_ok` is high; superframes without sync are skipped entirely.
  - `loop_req[lane]` rises after the pattern is seen in two consecutive sampled superframes.
  - It falls after two consecutive sampled superframes without the pattern.
  - It changes only in the clock after such a C3 bit.
- R8: With `sync_ok` high for a whole superframe, each lane receives 288 strobes, or 287 when its own subframe is stuffed. With `sync_ok` low for a whole superframe, no lane receives any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_bit | input | 1 | Line bit |
| in_valid | input | 1 | Line bit present this cycle |
| sync_ok | input | 1 | Frame aligner is locked |
| sf_idx | input | 2 | Subframe number of the line bit, 0..3 |
| blk_idx | input | 3 | Block number inside the subframe, 0..5 |
| pos_idx | input | 6 | Bit position inside the block, 0 = overhead |
| trib_bit | output | 4 | Recovered tributary data, one bit per lane |
| trib_vld | output | 4 | Per-lane strobe marking a new `trib_bit` |
| loop_req | output | 4 | Filtered loopback request per lane |

## Verification
The hardest situation to reach is the loopback filter's memory across superframes in which the aligner reports loss of sync. A lane must keep its history through such a superframe, so that a pattern seen before the loss and one seen after it together raise the request.

The stimulus table is ordered to produce exactly that. A lane sees the pattern once, then a superframe arrives without sync, then the lane sees the pattern again. Other entries alternate the pattern with clean superframes, so that a single hit or a single miss never moves the request.

// File: rtl/t2dm_pkg.sv
package t2dm_pkg;

  // Loopback command: first two control bits agree, the third disagrees.
  function automatic logic c_loop(input logic c1, input logic c2, input logic c3);
    return (c1 == c2) && (c3 != c1);
  endfunction

  // Stuff vote: majority of ones, unless the pattern is a loopback command.
  function automatic logic c_stuff(input logic c1, input logic c2, input logic c3);
    return !c_loop(c1, c2, c3) && ((c1 & c2) | (c1 & c3) | (c2 & c3));
  endfunction

  // Odd lanes travel inverted on the line.
  function automatic logic lane_inverted(input logic [1:0] lane);
    return lane[0];
  endfunction

endpackage

// File: rtl/t2dm_payload_map.sv
module t2dm_payload_map #(
  parameter int PW = 6,
  parameter int LW = 2
) (
  input  logic [PW-1:0] pos,
  output logic          is_payload,
  output logic [PW-1:0] slot,
  output logic [LW-1:0] lane,
  output logic          invert
);
  always_comb begin
    is_payload = (pos != '0);
    slot       = pos - PW'(1);
    lane       = slot[LW-1:0];
    invert     = t2dm_pkg::lane_inverted(lane);
  end
endmodule

// File: rtl/t2dm_cbit_vote.sv
module t2dm_cbit_vote #(
  parameter int BW     = 3,
  parameter int C1_BLK = 1,
  parameter int C2_BLK = 3,
  parameter int C3_BLK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_bit,
  input  logic          ovh,
  input  logic [BW-1:0] blk,
  output logic          c3_evt,
  output logic          loop_hit,
  output logic          stuff_armed
);
  logic c1_q, c2_q;

  assign c3_evt   = ovh && (blk == BW'(C3_BLK));
  assign loop_hit = t2dm_pkg::c_loop(c1_q, c2_q, in_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q        <= 1'b0;
      c2_q        <= 1'b0;
      stuff_armed <= 1'b0;
    end else begin
      if (ovh && blk == BW'(C1_BLK)) c1_q <= in_bit;
      if (ovh && blk == BW'(C2_BLK)) c2_q <= in_bit;
      if (c3_evt)
        stuff_armed <= t2dm_pkg::c_stuff(c1_q, c2_q, in_bit);
      else if (ovh && blk == '0)
        stuff_armed <= 1'b0;
    end
  end
endmodule

// File: rtl/t2dm_loop_filt.sv
module t2dm_loop_filt (
  input  logic clk,
  input  logic rst_n,
  input  logic eval,
  input  logic hit,
  output logic req
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      req    <= 1'b0;
    end else if (eval) begin
      seen_q <= hit;
      if (hit && seen_q)        req <= 1'b1;
      else if (!hit && !seen_q) req <= 1'b0;
    end
  end
endmodule

// File: rtl/t2dm_demux.sv
module t2dm_demux #(
  parameter int NTRIB    = 4,
  parameter int NBLK     = 6,
  parameter int BLK_BITS = 49
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_bit,
  input  logic                     in_valid,
  input  logic                     sync_ok,
  input  logic [$clog2(NTRIB)-1:0] sf_idx,
  input  logic [$clog2(NBLK)-1:0]  blk_idx,
  input  logic [$clog2(BLK_BITS)-1:0] pos_idx,
  output logic [NTRIB-1:0]         trib_bit,
  output logic [NTRIB-1:0]         trib_vld,
  output logic [NTRIB-1:0]         loop_req
);
  localparam int SW        = $clog2(NTRIB);
  localparam int BW        = $clog2(NBLK);
  localparam int PW        = $clog2(BLK_BITS);
  localparam int STUFF_BLK = NBLK - 1;

  logic          is_payload, invert;
  logic [PW-1:0] slot;
  logic [SW-1:0] lane;
  logic          ovh, c3_evt, loop_hit, stuff_armed;
  logic          stuff_slot, stuff_drop, strobe;

  assign ovh = in_valid && (pos_idx == '0);

  t2dm_payload_map #(.PW(PW), .LW(SW)) u_map (
    .pos(pos_idx), .is_payload(is_payload), .slot(slot),
    .lane(lane), .invert(invert)
  );

  t2dm_cbit_vote #(.BW(BW)) u_vote (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .ovh(ovh), .blk(blk_idx),
    .c3_evt(c3_evt), .loop_hit(loop_hit), .stuff_armed(stuff_armed)
  );

  // Stuff slot moves with the subframe: payload slot index equals subframe.
  assign stuff_slot = in_valid && is_payload &&
                      (blk_idx == BW'(STUFF_BLK)) && (slot == PW'(sf_idx));
  assign stuff_drop = stuff_slot && stuff_armed;
  assign strobe     = in_valid && sync_ok && is_payload && !stuff_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trib_vld <= '0;
      trib_bit <= '0;
    end else begin
      trib_vld <= '0;
      if (strobe) begin
        trib_vld[lane] <= 1'b1;
        trib_bit[lane] <= in_bit ^ invert;
      end
    end
  end

  for (genvar i = 0; i < NTRIB; i++) begin : g_loop
    logic eval_i;
    assign eval_i = c3_evt && sync_ok && (sf_idx == SW'(i));
    t2dm_loop_filt u_filt (
      .clk(clk), .rst_n(rst_n), .eval(eval_i), .hit(loop_hit), .req(loop_req[i])
    );
  end
endmodule

module t2dm_demux_chk #(
  parameter int NTRIB = 4,
  parameter int PW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             sync_ok,
  input logic [PW-1:0]    pos_idx,
  input logic             stuff_drop,
  input logic             c3_evt,
  input logic [NTRIB-1:0] trib_vld,
  input logic [NTRIB-1:0] loop_req
);
  // R2
  onehot_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trib_vld));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !sync_ok) |=> (trib_vld == '0));

  // R4
  overhead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pos_idx == '0) |=> (trib_vld == '0));

  // R6
  stuff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_drop |=> (trib_vld == '0));

  // R7
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(c3_evt && sync_ok) |=> $stable(loop_req));
endmodule

bind t2dm_demux t2dm_demux_chk #(.NTRIB(NTRIB), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sync_ok(sync_ok),
  .pos_idx(pos_idx), .stuff_drop(stuff_drop), .c3_evt(c3_evt),
  .trib_vld(trib_vld), .loop_req(loop_req)
);

// File: tb/tb_t2dm_demux.sv
`timescale 1ns/1ps
module tb_t2dm_demux;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_bit = 1'b0, in_valid = 1'b0, sync_ok = 1'b0;
  logic [1:0] sf_idx = '0;
  logic [2:0] blk_idx = '0;
  logic [5:0] pos_idx = '0;
  logic [3:0] trib_bit, trib_vld, loop_req;

  always #10 clk = ~clk;

  t2dm_demux dut (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .sync_ok(sync_ok), .sf_idx(sf_idx), .blk_idx(blk_idx), .pos_idx(pos_idx),
    .trib_bit(trib_bit), .trib_vld(trib_vld), .loop_req(loop_req)
  );

  int n_chk = 0, n_err = 0, gcnt = 0, bad_bits = 0;
  int lane_cnt [4];
  logic [15:0] lf = 16'hACE1;
  logic done = 1'b0;

  // {sync, S3, S2, S1, S0 (each {C1,C2,C3}), expected loop_req after the superframe}
  localparam logic [16:0] VEC [15] = '{
    {1'b1, 3'b000, 3'b000, 3'b000, 3'b000, 4'b0000},
    {1'b1, 3'b111, 3'b111, 3'b111, 3'b111, 4'b0000},
    {1'b1, 3'b100, 3'b011, 3'b101, 3'b110, 4'b0000},
    {1'b1, 3'b000, 3'b001, 3'b010, 3'b110, 4'b0001},
    {1'b1, 3'b101, 3'b001, 3'b111, 3'b000, 4'b0101},
    {1'b1, 3'b000, 3'b111, 3'b011, 3'b000, 4'b0100},
    {1'b1, 3'b111, 3'b111, 3'b110, 3'b010, 4'b0000},
    {1'b1, 3'b000, 3'b000, 3'b000, 3'b000, 4'b0000},
    {1'b1, 3'b000, 3'b000, 3'b110, 3'b000, 4'b0000},
    {1'b0, 3'b111, 3'b111, 3'b110, 3'b111, 4'b0000},
    {1'b1, 3'b000, 3'b000, 3'b110, 3'b000, 4'b0010},
    {1'b1, 3'b001, 3'b000, 3'b001, 3'b000, 4'b0010},
    {1'b1, 3'b001, 3'b000, 3'b000, 3'b000, 4'b1010},
    {1'b1, 3'b000, 3'b000, 3'b000, 3'b000, 4'b1000},
    {1'b1, 3'b000, 3'b000, 3'b000, 3'b000, 4'b0000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic stuffed(input logic [2:0] c);
    case (c)
      3'b111, 3'b101, 3'b011: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  task automatic send_frame(input logic [11:0] cp, input logic sy);
    bad_bits = 0;
    for (int i = 0; i < 4; i++) lane_cnt[i] = 0;
    for (int sf = 0; sf < 4; sf++) begin
      logic [2:0] c;
      logic st;
      c  = cp[3*sf +: 3];
      st = stuffed(c);
      for (int blk = 0; blk < 6; blk++) begin
        for (int pos = 0; pos < 49; pos++) begin
          logic b, ev;
          int ln;
          gcnt++;
          if (gcnt % 11 == 0) begin     // R4: idle cycle inserted
            in_valid = 1'b0;
            @(negedge clk);
            if (trib_vld != 4'b0) bad_bits++;
          end
          if (pos == 0) begin
            case (blk)
              0: b = (sf == 0) ? 1'b0 : 1'b1;
              1: b = c[2];
              2: b = 1'b0;
              3: b = c[1];
              4: b = c[0];
              default: b = 1'b1;
            endcase
          end else begin
            b  = lf[0];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          end
          in_valid = 1'b1; in_bit = b; sync_ok = sy;
          sf_idx = 2'(sf); blk_idx = 3'(blk); pos_idx = 6'(pos);
          @(negedge clk);
          ln = (pos + 3) % 4;
          ev = (pos != 0) && sy && !(blk == 5 && pos - 1 == sf && st);
          if (ev) begin
            if (trib_vld != (4'b0001 << ln) ||
                trib_bit[ln] != (b ^ (ln == 1 || ln == 3))) bad_bits++;
          end else if (trib_vld != 4'b0) bad_bits++;
          for (int i = 0; i < 4; i++) lane_cnt[i] += int'(trib_vld[i]);
        end
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 trib_vld at reset", int'(trib_vld), 0);
    chk("R1 trib_bit at reset", int'(trib_bit), 0);
    chk("R1 loop_req at reset", int'(loop_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 15; v++) begin
      logic [16:0] vec;
      vec = VEC[v];
      send_frame(vec[15:4], vec[16]);
      chk($sformatf("R2 R3 R4 R6 bit mismatches vec %0d", v), bad_bits, 0);
      for (int i = 0; i < 4; i++)
        chk($sformatf("R8 R5 lane %0d strobe count vec %0d", i, v), lane_cnt[i],
            vec[16] ? 288 - int'(stuffed(vec[4 + 3*i +: 3])) : 0);
      chk($sformatf("R7 loop_req vec %0d", v), int'(loop_req), int'(vec[3:0]));
    end

    // R7 then R1: raise a request on lane 3, reset, and confirm history is gone
    send_frame(12'b110_000_000_000, 1'b1);
    send_frame(12'b110_000_000_000, 1'b1);
    chk("R7 loop_req lane 3 raised", int'(loop_req), 8);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 loop_req cleared by reset", int'(loop_req), 0);
    chk("R1 trib_bit cleared by reset", int'(trib_bit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_frame(12'b110_000_000_000, 1'b1);
    chk("R1 R7 single hit after reset", int'(loop_req), 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end
endmodule